// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Controller

This block sits on a game-console cartridge between the CPU bus, the picture unit's pattern bus and the cartridge's ROM and RAM arrays. It turns the CPU's 32 KB program window and the 8 KB pattern window into physical ROM addresses, selects the nametable mirroring arrangement, and flags accesses to the 8 KB battery RAM window at 0x6000-0x7FFF.

Software programs the block through writes anywhere in 0x8000-0xFFFF. Each write carries only one data bit. The block collects five of these bits in a shift register, using a marker bit to know when it is full. On the fifth write it copies the collected value into one of four configuration registers. The address of that fifth write chooses which register. A write with data bit 7 set cancels any partial load. It also forces the program layout into the mode that keeps the last bank fixed at the top of the window.

Bank counts are parameters and must be powers of two: 4 to 16 program banks of 16 KB, and 4 to 32 pattern banks of 4 KB. Out-of-range bank numbers wrap by dropping their high bits.

Top module: `serial_bank_ctl`

## Requirements
- R1: After reset the shift register is empty (0x10) and the control register is 0x0C. The pattern A, pattern B and program bank registers are 0. So `mirror_o` is 0 and CPU address 0xC000 maps to the first byte of the last program bank.
- R2: A loader write (a CPU write with address bit 15 set) whose data bit 7 is 1 empties the shift register and ORs the control register with 0x0C. It commits no register and leaves control bits 4, 1 and 0 unchanged.
- R3: Every other loader write shifts the register right and puts data bit 0 into bit 4; data bits 6:1 are ignored. The fifth such write since the register was last empty commits, so the first write's bit becomes bit 0 of the value. CPU writes below 0x8000 have no effect on any register.
- R4: On commit, address bits 14:13 of that fifth write pick the target: 0 control, 1 pattern bank A, 2 pattern bank B, 3 program bank. No other register changes, and no register changes on a cycle without a loader write.
- R5: `mirror_o` equals control bits 1:0, encoded 0 single-screen lower, 1 single-screen upper, 2 vertical, 3 horizontal.
- R6: With control bits 3:2 equal to 0 or 1, the program window is one 32 KB bank. The 16 KB bank index is the program bank value with bit 0 replaced by CPU address bit 14, and `prog_addr_o` = {bank, cpu_addr_i[13:0]}.
- R7: With control bits 3:2 equal to 2, CPU addresses 0x8000-0xBFFF use bank 0 and 0xC000-0xFFFF use the program bank value.
- R8: With control bits 3:2 equal to 3, CPU addresses 0x8000-0xBFFF use the program bank value and 0xC000-0xFFFF use the last bank (PROG_BANKS-1).
- R9: With control bit 4 = 0, the pattern window is one 8 KB bank: the 4 KB index is pattern A with bit 0 replaced by pattern address bit 12. With bit 4 = 1, pattern addresses below 0x1000 use pattern A and the rest use pattern B. In both cases `pat_addr_o` = {index, ppu_addr_i[11:0]}.
- R10: Only the low 4 bits of the program bank value are used. Every bank number is taken modulo the bank count of its array.
- R11: `sram_en_o` is 1 exactly when `cpu_addr_i` is in 0x6000-0x7FFF, whether or not a write is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| ppu_addr_i | input | 13 | Pattern-bus address (0x0000-0x1FFF) |
| prog_addr_o | output | PROG_AW (17) | Physical program ROM address |
| pat_addr_o | output | PAT_AW (17) | Physical pattern ROM address |
| mirror_o | output | 2 | Nametable mirroring arrangement |
| sram_en_o | output | 1 | Battery RAM window select |

## Verification
The bound checker watches several properties on every cycle:
- a cancelling write forces the fixed-last layout and empties the loader;
- a commit happens on exactly the fifth serial write and never sooner;
- the control register holds when there is no loader write;
- the fixed-bank halves of modes 2 and 3 map correctly;
- in 8 KB mode the pattern half follows the address.

Which register a commit reaches, and the values of the switched banks, are left to the bench's reference model. So are the wrap of oversized bank numbers, the ignored data bits, and the writes below 0x8000. The model checks all of these through address sweeps after each reconfiguration.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam logic [4:0] SHIFT_EMPTY = 5'b10000;
  localparam logic [4:0] CTRL_RESET  = 5'b01100;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_PAT_A = 2'd1,
    TGT_PAT_B = 2'd2,
    TGT_PROG  = 2'd3
  } target_e;
endpackage

// File: rtl/sbc_loader.sv
module sbc_loader
  import sbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_wr_i,
  input  logic [7:0] data_i,
  output logic       wipe_o,
  output logic       commit_o,
  output logic [4:0] value_o,
  output logic [4:0] shift_o
);
  logic [4:0] shift_q;
  logic [4:0] shift_nxt;

  assign shift_nxt = {data_i[0], shift_q[4:1]};
  assign wipe_o    = ld_wr_i & data_i[7];
  // marker bit reaching bit 0 means four bits are already held
  assign commit_o  = ld_wr_i & ~data_i[7] & shift_q[0];
  assign value_o   = shift_nxt;
  assign shift_o   = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   shift_q <= SHIFT_EMPTY;
    else if (wipe_o || commit_o)   shift_q <= SHIFT_EMPTY;
    else if (ld_wr_i)              shift_q <= shift_nxt;
  end
endmodule

// File: rtl/sbc_regs.sv
module sbc_regs
  import sbc_pkg::*;
#(
  parameter int PB  = 3,
  parameter int PCB = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wipe_i,
  input  logic           commit_i,
  input  logic [1:0]     sel_i,
  input  logic [4:0]     value_i,
  output logic [4:0]     ctrl_o,
  output logic [PCB-1:0] pat_a_o,
  output logic [PCB-1:0] pat_b_o,
  output logic [PB-1:0]  prog_o
);
  target_e tgt;
  assign tgt = target_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= CTRL_RESET;
      pat_a_o <= '0;
      pat_b_o <= '0;
      prog_o  <= '0;
    end else if (wipe_i) begin
      ctrl_o  <= ctrl_o | CTRL_RESET;
    end else if (commit_i) begin
      unique case (tgt)
        TGT_CTRL:  ctrl_o  <= value_i;
        TGT_PAT_A: pat_a_o <= value_i[PCB-1:0];
        TGT_PAT_B: pat_b_o <= value_i[PCB-1:0];
        TGT_PROG:  prog_o  <= value_i[PB-1:0];
      endcase
    end
  end
endmodule

// File: rtl/sbc_prog_map.sv
module sbc_prog_map #(
  parameter int PB = 3
) (
  input  logic [1:0]     mode_i,
  input  logic [PB-1:0]  prog_i,
  input  logic [14:0]    addr_i,
  output logic [PB+13:0] rom_addr_o
);
  logic          win;
  logic [PB-1:0] bank;

  assign win = addr_i[14];

  always_comb begin
    unique case (mode_i)
      2'd2:    bank = win ? prog_i : '0;
      2'd3:    bank = win ? '1 : prog_i;
      default: bank = {prog_i[PB-1:1], win};
    endcase
  end

  assign rom_addr_o = {bank, addr_i[13:0]};
endmodule

// File: rtl/sbc_pat_map.sv
module sbc_pat_map #(
  parameter int PCB = 5
) (
  input  logic           split_i,
  input  logic [PCB-1:0] pat_a_i,
  input  logic [PCB-1:0] pat_b_i,
  input  logic [12:0]    addr_i,
  output logic [PCB+11:0] rom_addr_o
);
  logic           half;
  logic [PCB-1:0] bank;

  assign half = addr_i[12];

  always_comb begin
    if (split_i) bank = half ? pat_b_i : pat_a_i;
    else         bank = {pat_a_i[PCB-1:1], half};
  end

  assign rom_addr_o = {bank, addr_i[11:0]};
endmodule

// File: rtl/serial_bank_ctl.sv
module serial_bank_ctl #(
  parameter int PROG_BANKS = 8,
  parameter int PAT_BANKS  = 32,
  localparam int PB      = $clog2(PROG_BANKS),
  localparam int PCB     = $clog2(PAT_BANKS),
  localparam int PROG_AW = PB + 14,
  localparam int PAT_AW  = PCB + 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_wr_i,
  input  logic [15:0]        cpu_addr_i,
  input  logic [7:0]         cpu_data_i,
  input  logic [12:0]        ppu_addr_i,
  output logic [PROG_AW-1:0] prog_addr_o,
  output logic [PAT_AW-1:0]  pat_addr_o,
  output logic [1:0]         mirror_o,
  output logic               sram_en_o
);
  logic           ld_wr;
  logic           wipe;
  logic           commit;
  logic [4:0]     value;
  logic [4:0]     shift_q;
  logic [4:0]     ctrl_q;
  logic [PCB-1:0] pat_a_q;
  logic [PCB-1:0] pat_b_q;
  logic [PB-1:0]  prog_q;

  assign ld_wr = cpu_wr_i & cpu_addr_i[15];

  sbc_loader u_loader (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_wr_i  (ld_wr),
    .data_i   (cpu_data_i),
    .wipe_o   (wipe),
    .commit_o (commit),
    .value_o  (value),
    .shift_o  (shift_q)
  );

  sbc_regs #(.PB(PB), .PCB(PCB)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wipe_i   (wipe),
    .commit_i (commit),
    .sel_i    (cpu_addr_i[14:13]),
    .value_i  (value),
    .ctrl_o   (ctrl_q),
    .pat_a_o  (pat_a_q),
    .pat_b_o  (pat_b_q),
    .prog_o   (prog_q)
  );

  sbc_prog_map #(.PB(PB)) u_prog_map (
    .mode_i     (ctrl_q[3:2]),
    .prog_i     (prog_q),
    .addr_i     (cpu_addr_i[14:0]),
    .rom_addr_o (prog_addr_o)
  );

  sbc_pat_map #(.PCB(PCB)) u_pat_map (
    .split_i    (ctrl_q[4]),
    .pat_a_i    (pat_a_q),
    .pat_b_i    (pat_b_q),
    .addr_i     (ppu_addr_i),
    .rom_addr_o (pat_addr_o)
  );

  assign mirror_o  = ctrl_q[1:0];
  assign sram_en_o = (cpu_addr_i[15:13] == 3'b011);
endmodule

// File: rtl/serial_bank_ctl_chk.sv
module serial_bank_ctl_chk #(
  parameter int PB = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ld_wr_i,
  input logic          hi_i,
  input logic          commit_i,
  input logic [1:0]    win_i,
  input logic          ppu_half_i,
  input logic [4:0]    ctrl_i,
  input logic [4:0]    shift_i,
  input logic [PB-1:0] bank_i,
  input logic          pat_half_i
);
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (ld_wr_i && (hi_i || commit_i)) cnt_q <= '0;
    else if (ld_wr_i)             cnt_q <= cnt_q + 3'd1;
  end

  a_r2_wipe_forces_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wr_i && hi_i |=> ctrl_i[3:2] == 2'b11 && shift_i == 5'b10000
      && ctrl_i[1:0] == $past(ctrl_i[1:0]) && ctrl_i[4] == $past(ctrl_i[4]));

  a_r3_commit_only_fifth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> cnt_q == 3'd4);

  a_r3_fifth_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wr_i && !hi_i && cnt_q == 3'd4 |-> commit_i);

  a_r4_ctrl_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_wr_i |=> $stable(ctrl_i));

  a_r7_first_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[3:2] == 2'b10 && win_i == 2'b10 |-> bank_i == '0);

  a_r8_last_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[3:2] == 2'b11 && win_i == 2'b11 |-> &bank_i);

  a_r9_8k_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[4] |-> pat_half_i == ppu_half_i);
endmodule

bind serial_bank_ctl serial_bank_ctl_chk #(.PB(PB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ld_wr_i    (ld_wr),
  .hi_i       (cpu_data_i[7]),
  .commit_i   (commit),
  .win_i      (cpu_addr_i[15:14]),
  .ppu_half_i (ppu_addr_i[12]),
  .ctrl_i     (ctrl_q),
  .shift_i    (shift_q),
  .bank_i     (prog_addr_o[PROG_AW-1:14]),
  .pat_half_i (pat_addr_o[12])
);

// File: tb/serial_bank_ctl_bench.sv
module serial_bank_ctl_bench;
  localparam int NPROG = 8;
  localparam int NPAT  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic [12:0] paddr = 13'h0000;
  logic [16:0] prog_addr;
  logic [16:0] pat_addr;
  logic [1:0]  mirror;
  logic        sram_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_sh = 16, m_ctrl = 12, m_a = 0, m_b = 0, m_p = 0;

  always #4 clk = ~clk;

  serial_bank_ctl #(.PROG_BANKS(NPROG), .PAT_BANKS(NPAT)) u_serial_bank_ctl (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_addr_i(addr),
    .cpu_data_i(data), .ppu_addr_i(paddr), .prog_addr_o(prog_addr),
    .pat_addr_o(pat_addr), .mirror_o(mirror), .sram_en_o(sram_en));

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_prog(int a);
    int mode = (m_ctrl >> 2) & 3;
    int win = (a >> 14) & 1;
    int p4 = m_p & 15;
    int bank;
    if (mode < 2)       bank = (p4 & ~1) + win;
    else if (mode == 2) bank = win ? p4 : 0;
    else                bank = win ? NPROG - 1 : p4;
    return (bank % NPROG) * 16384 + (a % 16384);
  endfunction

  function automatic int exp_pat(int pa);
    int half = (pa >> 12) & 1;
    int bank;
    if (((m_ctrl >> 4) & 1) == 0) bank = (m_a & ~1) + half;
    else                          bank = half ? m_b : m_a;
    return (bank % NPAT) * 4096 + (pa % 4096);
  endfunction

  function automatic void model_write(int a, int d);
    int full;
    if (a < 32768) return;
    if ((d & 128) != 0) begin
      m_sh = 16;
      m_ctrl = m_ctrl | 12;
      return;
    end
    full = m_sh & 1;
    m_sh = (m_sh >> 1) | ((d & 1) << 4);
    if (full == 1) begin
      case ((a >> 13) & 3)
        0: m_ctrl = m_sh;
        1: m_a = m_sh;
        2: m_b = m_sh;
        default: m_p = m_sh;
      endcase
      m_sh = 16;
    end
  endfunction

  // compare every output with the model on every clock
  always @(posedge clk) begin
    if (rst_n && !done) begin
      #3;
      check_eq({cur_req, " prog_addr"}, int'(prog_addr), exp_prog(int'(addr)));
      check_eq({cur_req, " pat_addr"}, int'(pat_addr), exp_pat(int'(paddr)));
      check_eq({cur_req, " mirror"}, int'(mirror), m_ctrl & 3);
      check_eq({cur_req, " sram_en"}, int'(sram_en),
               (int'(addr) >= 24576 && int'(addr) < 32768) ? 1 : 0);
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      report();
    end
  end

  task automatic cpu_write(int a, int d);
    @(negedge clk);
    addr = 16'(a); data = 8'(d); wr = 1'b1;
    @(posedge clk);
    #1 model_write(a, d);
    @(negedge clk);
    wr = 1'b0; data = 8'h00;
  endtask

  task automatic load5(int a, int val);
    for (int i = 0; i < 5; i++)
      cpu_write(a, ((val >> i) & 1) | 8'h3E);  // bits 6:1 are noise
  endtask

  task automatic sweep();
    int cas[6] = '{24576, 32767, 32768, 41251, 49152, 65535};
    int pas[4] = '{0, 4095, 4096, 6844};
    foreach (cas[i])
      foreach (pas[j]) begin
        @(negedge clk);
        addr = 16'(cas[i]); paddr = 13'(pas[j]);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    addr = 16'hC000; paddr = 13'h0000;
    @(negedge clk);
    check_eq("R1 last bank at C000", int'(prog_addr), 7 * 16384);
    check_eq("R1 mirror", int'(mirror), 0);
    check_eq("R1 pattern bank 0", int'(pat_addr), 0);
    sweep();

    // R11 and R3: window flag, low writes ignored
    cur_req = "R11";
    addr = 16'h5FFF; @(negedge clk);
    check_eq("R11 below window", int'(sram_en), 0);
    addr = 16'h6000; wr = 1'b1; @(negedge clk); wr = 1'b0;
    check_eq("R11 window during write", int'(sram_en), 1);
    cur_req = "R3";
    cpu_write(16'h6000, 8'h01);
    cpu_write(16'h7FFF, 8'h81);
    sweep();

    // R4 R5: control to vertical, 32K program mode
    cur_req = "R5";
    load5(16'h8000, 5'h02);
    check_eq("R5 vertical", int'(mirror), 2);
    cur_req = "R6";
    load5(16'hE000, 5'h05);
    sweep();

    // R7 mode 2, R8 mode 3, R10 wrap and low-4 use
    cur_req = "R7";
    load5(16'h9FFF, 5'h08);
    sweep();
    cur_req = "R8";
    load5(16'h8000, 5'h0F);
    check_eq("R5 horizontal", int'(mirror), 3);
    sweep();
    cur_req = "R10";
    load5(16'hFFFF, 5'h1B);
    sweep();

    // R9: pattern banks, 8K then 4K
    cur_req = "R9";
    load5(16'hA000, 5'h07);
    load5(16'hC000, 5'h1E);
    sweep();
    load5(16'h8000, 5'h1D);
    check_eq("R5 single upper", int'(mirror), 1);
    sweep();

    // R2: cancel a partial load, then mode forced to 3
    cur_req = "R2";
    load5(16'h8000, 5'h10);
    cpu_write(16'hE000, 8'h01);
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'h9000, 8'h80);
    sweep();
    // three more writes would commit only if the partial bits survived
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hE000, 8'h01);
    cpu_write(16'hE000, 8'h00);
    sweep();
    cur_req = "R4";
    // first four writes at one address, fifth selects the target
    for (int i = 0; i < 4; i++) cpu_write(16'h8000, (6 >> i) & 1);
    cpu_write(16'hE000, 1);
    sweep();
    load5(16'hC000, 5'h03);
    sweep();

    done = 1;
    @(negedge clk);
    report();
  end
endmodule